// File: doc/BRIEF.md
# Sticky Maskable Interrupt Generator

This block gathers five level-type alarm flags from a receiver and presents them two ways. A live status register shows the flags as they are now. A history register latches every flag that has been seen, so a short alarm is still visible later. The history is ANDed with a per-bit enable mask, and any surviving bit drives one interrupt pin. The pin's polarity and its drive style, push-pull or open-drain, can be configured. The pin is modelled as a data value plus an output-enable, so several blocks can share one wired line.

Software reaches the registers through a simple one-cycle read/write port. A read of the history register returns its contents. It then clears only the bits whose alarm is absent in that cycle. A bit whose alarm is still present stays set, and so does a bit whose alarm first appears in the read cycle. While an enabled bit stays set, the pin holds a steady level.

Top module: `irq_gen`

## Requirements
- R1: After reset, the history and mask registers are zero and the configuration is open-drain, active low, so the pin is released (`pin_oe_o`=0, `pin_o`=1).
- R2: A read of address 01h returns the live event flags in bits 4:0, one cycle after the request. Reading it changes nothing.
- R3: An asserted event sets its history bit at the next clock edge. The bit stays set after the event goes away, until a history read clears it. The bit order is: 0 loss of signal, 1 in-window, 2 temperature alarm, 3 loss of lock, 4 FIFO over/underflow.
- R4: The history register records events whatever the mask holds.
- R5: A read of address 00h returns the history. At that same edge, each history bit becomes the level of its event in the read cycle. Bits of absent events are cleared; bits of present or newly asserted events stay set.
- R6: The mask at address A0h enables a history bit onto the pin when that mask bit is 1. The pin is asserted exactly when (history AND mask) is non-zero.
- R7: The configuration at address A5h selects push-pull when bit 0 is 1 (open-drain when 0) and active-high when bit 1 is 1 (active-low when 0). It reads back in bits 1:0.
- R8: In open-drain mode, `pin_oe_o` is 1 only while the pin is asserted. In push-pull mode, `pin_oe_o` is always 1. `pin_o` carries the asserted level while asserted and the opposite level otherwise.
- R9: Reserved and unimplemented bits read as 0, and unmapped addresses read 0. Writes to 00h, 01h and unmapped addresses have no effect.
- R10: While an enabled history bit stays set, the pin holds a constant level across repeated history reads, with no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 5 | Event level flags, bit order as R3 |
| req_i | input | 1 | Register access request, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, updated one cycle after a read request |
| pin_o | output | 1 | Interrupt pin drive value |
| pin_oe_o | output | 1 | Interrupt pin output-enable |

## Verification
Read data appears and the history clears at the same clock edge that samples the request, so the bench drives on the falling edge and samples one time unit after the next rising edge. An event or a mask or configuration write takes effect on the pin after one edge. The pin is combinational from those registers, so the bench checks it half a cycle after the edge that loaded them. For the no-pulse rule, the pin is sampled after every edge of a run of back-to-back history reads.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_EVT = 5;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 8;

  localparam logic [7:0] ADDR_HIST = 8'h00;
  localparam logic [7:0] ADDR_STAT = 8'h01;
  localparam logic [7:0] ADDR_MASK = 8'hA0;
  localparam logic [7:0] ADDR_CFG  = 8'hA5;

  typedef struct packed {
    logic act_high;
    logic push_pull;
  } pin_cfg_t;
endpackage

// File: rtl/irq_hist.sv
module irq_hist #(
  parameter int unsigned NUM_EVT = irq_pkg::NUM_EVT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               clr_i,
  output logic [NUM_EVT-1:0] hist_o
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    // on read: keep only still-present events (incl. new ones this cycle)
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    hist_o[i] <= 1'b0;
      else if (clr_i) hist_o[i] <= evt_i[i];
      else            hist_o[i] <= hist_o[i] | evt_i[i];
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int unsigned NUM_EVT = irq_pkg::NUM_EVT,
  parameter int unsigned DATA_W  = irq_pkg::DATA_W,
  parameter int unsigned ADDR_W  = irq_pkg::ADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] hist_i,
  output logic [NUM_EVT-1:0] mask_o,
  output pin_cfg_t           cfg_o,
  output logic               hist_rd_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam logic [ADDR_W-1:0] A_HIST = ADDR_W'(ADDR_HIST);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADDR_MASK);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(ADDR_CFG);

  logic rd, wr;
  logic [DATA_W-1:0] rd_val;

  assign rd        = req_i & ~we_i;
  assign wr        = req_i &  we_i;
  assign hist_rd_o = rd && (addr_i == A_HIST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      cfg_o  <= '0;
    end else if (wr) begin
      if (addr_i == A_MASK) mask_o <= wdata_i[NUM_EVT-1:0];
      if (addr_i == A_CFG)  cfg_o  <= pin_cfg_t'(wdata_i[1:0]);
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (addr_i)
      A_HIST:  rd_val[NUM_EVT-1:0] = hist_i;
      A_STAT:  rd_val[NUM_EVT-1:0] = evt_i;
      A_MASK:  rd_val[NUM_EVT-1:0] = mask_o;
      A_CFG:   rd_val[1:0]         = cfg_o;
      default: rd_val              = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_val;
  end
endmodule

// File: rtl/irq_pin.sv
module irq_pin
  import irq_pkg::*;
#(
  parameter int unsigned NUM_EVT = irq_pkg::NUM_EVT
) (
  input  logic [NUM_EVT-1:0] hist_i,
  input  logic [NUM_EVT-1:0] mask_i,
  input  pin_cfg_t           cfg_i,
  output logic               pin_o,
  output logic               pin_oe_o
);
  logic active;

  assign active   = |(hist_i & mask_i);
  assign pin_o    = active ? cfg_i.act_high : ~cfg_i.act_high;
  // open-drain: drive only the asserted level, release otherwise
  assign pin_oe_o = cfg_i.push_pull | active;
endmodule

// File: rtl/irq_gen.sv
module irq_gen
  import irq_pkg::*;
#(
  parameter int unsigned NUM_EVT = irq_pkg::NUM_EVT,
  parameter int unsigned DATA_W  = irq_pkg::DATA_W,
  parameter int unsigned ADDR_W  = irq_pkg::ADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               pin_o,
  output logic               pin_oe_o
);
  logic [NUM_EVT-1:0] hist_q;
  logic [NUM_EVT-1:0] mask_q;
  pin_cfg_t           cfg_q;
  logic               hist_rd;

  irq_hist #(.NUM_EVT(NUM_EVT)) i_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .clr_i  (hist_rd),
    .hist_o (hist_q)
  );

  irq_regs #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .evt_i     (evt_i),
    .hist_i    (hist_q),
    .mask_o    (mask_q),
    .cfg_o     (cfg_q),
    .hist_rd_o (hist_rd),
    .rdata_o   (rdata_o)
  );

  irq_pin #(.NUM_EVT(NUM_EVT)) i_pin (
    .hist_i   (hist_q),
    .mask_i   (mask_q),
    .cfg_i    (cfg_q),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o)
  );
endmodule

// File: rtl/irq_gen_chk.sv
module irq_gen_chk #(
  parameter int unsigned NUM_EVT = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EVT-1:0] evt_i,
  input logic [NUM_EVT-1:0] hist_q,
  input logic [NUM_EVT-1:0] mask_q,
  input logic [1:0]         cfg_q,
  input logic               hist_rd,
  input logic               pin_o,
  input logic               pin_oe_o
);
  p_hist_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((hist_q & $past(evt_i)) == $past(evt_i)));

  p_hist_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hist_rd |=> ((hist_q & $past(hist_q)) == $past(hist_q)));

  p_clear_on_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist_rd |=> (hist_q == $past(evt_i)));

  p_pin_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((hist_q & mask_q) != '0) == (pin_o == cfg_q[1])));

  p_push_pull_oe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q[0] |-> pin_oe_o);

  p_od_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q[0] && !pin_oe_o) |-> (pin_o != cfg_q[1]));
endmodule

bind irq_gen irq_gen_chk #(.NUM_EVT(NUM_EVT)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .evt_i    (evt_i),
  .hist_q   (hist_q),
  .mask_q   (mask_q),
  .cfg_q    (cfg_q),
  .hist_rd  (hist_rd),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o)
);

// File: tb/test_irq_gen.sv
module test_irq_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] evt_i = '0;
  logic       req_i = 1'b0;
  logic       we_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       pin_o, pin_oe_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  irq_gen i_irq_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic acc(input bit we, input logic [7:0] a, input logic [7:0] d,
                     output logic [7:0] q);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    #1;
    q = rdata_o;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  // expected {oe, pin}
  function automatic logic [1:0] exp_pin(input bit act, input logic [1:0] cfg);
    logic lvl;
    lvl = cfg[1];
    return {cfg[0] | act, act ? lvl : ~lvl};
  endfunction

  task automatic load_hist(input logic [4:0] p);
    logic [7:0] q;
    evt_i = '0;
    acc(1'b0, 8'h00, 8'h00, q);
    @(negedge clk_i); evt_i = p;
    @(negedge clk_i); evt_i = '0;
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] q;
    logic [1:0] e;
    repeat (3) @(posedge clk_i);
    #1;
    chk(pin_o == 1'b1 && pin_oe_o == 1'b0, "R1 pin released", {pin_oe_o, pin_o}, 2'b01);
    chk(rdata_o == 8'h00, "R1 rdata", rdata_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    acc(1'b0, 8'h00, 8'h00, q); chk(q == 8'h00, "R1 history zero", q, 0);
    acc(1'b0, 8'hA0, 8'h00, q); chk(q == 8'h00, "R1 mask zero", q, 0);
    acc(1'b0, 8'hA5, 8'h00, q); chk(q == 8'h00, "R1 config zero", q, 0);

    // R2: live status over all patterns, read twice
    for (int p = 0; p < 32; p++) begin
      @(negedge clk_i); evt_i = 5'(p);
      acc(1'b0, 8'h01, 8'h00, q); chk(q == 8'(p), "R2 status", q, p);
      acc(1'b0, 8'h01, 8'h00, q); chk(q == 8'(p), "R2 status reread", q, p);
    end

    // R3/R4/R5: sticky capture with mask zero, clear when events gone
    for (int p = 0; p < 32; p++) begin
      load_hist(5'(p));
      repeat (2) @(negedge clk_i);
      chk(pin_oe_o == 1'b0, "R4 masked pin released", pin_oe_o, 0);
      acc(1'b0, 8'h00, 8'h00, q); chk(q == 8'(p), "R3 R4 sticky history", q, p);
      acc(1'b0, 8'h00, 8'h00, q); chk(q == 8'h00, "R5 cleared after read", q, 0);
    end

    // R6/R7/R8: config x mask x history sweep
    for (int c = 0; c < 4; c++) begin
      acc(1'b1, 8'hA5, 8'(c), q);
      acc(1'b0, 8'hA5, 8'h00, q); chk(q == 8'(c), "R7 config readback", q, c);
      for (int m = 0; m < 32; m++) begin
        acc(1'b1, 8'hA0, 8'(m), q);
        for (int p = 0; p < 32; p++) begin
          load_hist(5'(p));
          #1;
          e = exp_pin((p & m) != 0, 2'(c));
          chk({pin_oe_o, pin_o} == e, "R6 R8 pin", {pin_oe_o, pin_o}, e);
        end
      end
    end

    // R5: selective clear, and event new in read cycle kept
    acc(1'b1, 8'hA5, 8'h00, q);
    acc(1'b1, 8'hA0, 8'h00, q);
    load_hist(5'b10101);
    @(negedge clk_i); evt_i = 5'b00101;
    acc(1'b0, 8'h00, 8'h00, q); chk(q == 8'h15, "R5 read returns history", q, 8'h15);
    acc(1'b0, 8'h00, 8'h00, q); chk(q == 8'h05, "R5 present bits kept", q, 8'h05);
    @(negedge clk_i); evt_i = 5'b00000;
    acc(1'b0, 8'h00, 8'h00, q); chk(q == 8'h05, "R5 sticky before clear", q, 8'h05);
    @(negedge clk_i);
    req_i = 1'b1; addr_i = 8'h00; evt_i = 5'b01000;
    @(posedge clk_i); #1;
    chk(rdata_o == 8'h00, "R5 read before new event", rdata_o, 0);
    req_i = 1'b0; evt_i = 5'b00000;
    acc(1'b0, 8'h00, 8'h00, q); chk(q == 8'h08, "R5 event in read cycle kept", q, 8'h08);

    // R10: steady pin across back-to-back reads
    acc(1'b1, 8'hA0, 8'h1F, q);
    @(negedge clk_i); evt_i = 5'b00001;
    for (int k = 0; k < 6; k++) begin
      acc(1'b0, 8'h00, 8'h00, q);
      chk(pin_o == 1'b0 && pin_oe_o == 1'b1, "R10 pin held", {pin_oe_o, pin_o}, 2'b10);
      #3;
      chk(pin_o == 1'b0 && pin_oe_o == 1'b1, "R10 pin held mid", {pin_oe_o, pin_o}, 2'b10);
    end
    @(negedge clk_i); evt_i = '0;

    // R9: ignored writes and zero reserved bits
    load_hist(5'b00110);
    acc(1'b1, 8'h00, 8'hFF, q);
    acc(1'b1, 8'h01, 8'hFF, q);
    acc(1'b1, 8'h55, 8'hFF, q);
    acc(1'b0, 8'hA0, 8'h00, q); chk(q == 8'h1F, "R9 mask untouched by other writes", q, 8'h1F);
    acc(1'b0, 8'hA5, 8'h00, q); chk(q == 8'h00, "R9 config untouched", q, 0);
    acc(1'b0, 8'h00, 8'h00, q); chk(q == 8'h06, "R9 history untouched by write", q, 8'h06);
    acc(1'b0, 8'h55, 8'h00, q); chk(q == 8'h00, "R9 unmapped reads zero", q, 0);
    acc(1'b1, 8'hA0, 8'hFF, q);
    acc(1'b0, 8'hA0, 8'h00, q); chk(q == 8'h1F, "R9 mask reserved bits", q, 8'h1F);
    acc(1'b1, 8'hA5, 8'hFF, q);
    acc(1'b0, 8'hA5, 8'h00, q); chk(q == 8'h03, "R9 config reserved bits", q, 8'h03);
    @(negedge clk_i); evt_i = 5'b11111;
    acc(1'b0, 8'h01, 8'h00, q); chk(q == 8'h1F, "R9 status reserved bits", q, 8'h1F);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule